// File: doc/BRIEF.md
# Burst SRAM with Byte Lanes and Selectable Read Latency

This block is a synchronous single-port static memory of 64-bit words. The word depth is set by an address-width parameter. An address strobe registers a start address. A two-bit beat counter then produces the other three addresses of a four-beat burst, in either interleaved or linear order. Each write beat can update any mix of the eight byte lanes, or all of them through a global-write override. A static pin selects how read data leaves the block: flow-through (combinational from the array) or registered (one extra cycle).

Three chip enables, one active high and two active low, qualify the address strobe. A strobe sampled with any enable inactive ends the current burst and parks the block idle. The control FSM has two states. `S_IDLE` waits for a qualified strobe. `S_BURST` serves one beat per cycle at the current counter address. The transition *open* (`S_IDLE`→`S_BURST`) takes a qualified strobe. The transition *close* (`S_BURST`→`S_IDLE`) takes an unqualified strobe. A qualified strobe in `S_BURST` is the *restart* self-loop: it reloads the address. Any other cycle in `S_BURST` is the *beat* self-loop: it advances or holds the counter.

Read and write data use separate ports. An active-low output enable gates the read port asynchronously. With the enable high, the port shows zeros and a low valid flag.

Top module: `burst_sram`

## Requirements
- R1: While reset is low and right after it, `rvalid` is 0. `rdata` is all zeros whenever `rvalid` is 0.
- R2: A strobe (`strobe_n`=0) with `cs_hi`=1, `cs_lo_a_n`=0 and `cs_lo_b_n`=0 starts a burst at `addr`. A strobe with any enable inactive ends any burst and yields no read beats.
- R3: With `seq_linear`=0, the low two address bits of beat k are the start's low two bits XOR k. The upper bits stay fixed.
- R4: With `seq_linear`=1, the low two address bits of beat k are the start's low two bits plus k, modulo 4. The upper bits stay fixed.
- R5: The beat counter advances on each burst edge with `adv_n`=0 and `strobe_n`=1. With `adv_n`=1 it holds, and a read repeats the same beat.
- R6: `gwe_n`=0 writes all eight lanes of the beat, whatever `bwe_n` and `lane_we_n` are.
- R7: With `gwe_n`=1 and `bwe_n`=0, lane i (bits 8i+7..8i) is written exactly when `lane_we_n[i]`=0.
- R8: With `gwe_n`=1 and `bwe_n`=1, the beat is a read. `lane_we_n` is ignored and memory is unchanged.
- R9: With `flow_n`=0, the first beat is valid in the cycle right after the strobe edge. With `flow_n`=1, it is valid one cycle later, from a register.
- R10: `oe_n`=1 forces `rvalid` to 0 and `rdata` to 0 without a clock edge. Lowering `oe_n` restores the beat at once.
- R11: For a write beat, the write controls and `wdata` are sampled on the edge after its address becomes current; for beat 0 that is the edge after the strobe. A read beat carries the word last stored at its address.
- R12: A qualified strobe during a burst restarts at the new address on that edge. Two chained four-beat reads give eight consecutive valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Burst start address |
| cs_hi | input | 1 | Chip enable, active high |
| cs_lo_a_n | input | 1 | Chip enable, active low |
| cs_lo_b_n | input | 1 | Chip enable, active low |
| strobe_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Beat counter advance, active low |
| gwe_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | 8 | Per-lane write enables, active low |
| flow_n | input | 1 | Static: 0 flow-through, 1 registered read |
| seq_linear | input | 1 | Static: 1 linear order, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, zero when not valid |
| rvalid | output | 1 | Read beat valid |

## Verification
Fill bursts with global write store a distinct word at every address. Read bursts from unaligned starts in both orders then show whether the beat sequence is the XOR or the sum form. Byte writes with a sparse lane mask, global writes with every lane enable off, and unqualified write beats each change a different set of lanes, so one readback tells them apart. A held-advance read, an output-enable toggle inside a cycle, an unqualified strobe and two chained bursts separate the hold, gating, deselect and restart paths. The whole read set runs again in registered mode to show the one-cycle latency difference.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    typedef enum logic {S_IDLE, S_BURST} st_t;

    // Low two address bits of a beat from the start bits and beat count.
    function automatic logic [1:0] beat_lo(input logic [1:0] b,
                                           input logic [1:0] c,
                                           input logic       lin);
        return lin ? (b + c) : (b ^ c);
    endfunction

endpackage

// File: rtl/bsr_burst_seq.sv
`timescale 1ns/1ps
module bsr_burst_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output logic [1:0]    base_lo
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    assign cur_addr = {base_q[AW-1:2], bsr_pkg::beat_lo(base_q[1:0], cnt_q, linear)};
    assign base_lo  = base_q[1:0];
endmodule

// File: rtl/bsr_lane_array.sv
`timescale 1ns/1ps
module bsr_lane_array #(
    parameter int AW    = 6,
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic [LANES-1:0]   we,
    input  logic [AW-1:0]      addr,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[addr] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = cells[addr];
    end
endmodule

// File: rtl/bsr_out_stage.sv
`timescale 1ns/1ps
module bsr_out_stage #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_n,
    input  logic          oe_n,
    input  logic          live,
    input  logic [DW-1:0] core_data,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic          pipe_v;
    logic [DW-1:0] pipe_d;
    logic          raw_v;
    logic [DW-1:0] raw_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_v <= 1'b0;
            pipe_d <= '0;
        end else begin
            pipe_v <= live;
            pipe_d <= core_data;
        end
    end

    assign raw_v  = flow_n ? pipe_v : live;
    assign raw_d  = flow_n ? pipe_d : core_data;
    assign rvalid = raw_v & ~oe_n;
    assign rdata  = rvalid ? raw_d : '0;
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
    parameter int AW    = 6,
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr,
    input  logic               cs_hi,
    input  logic               cs_lo_a_n,
    input  logic               cs_lo_b_n,
    input  logic               strobe_n,
    input  logic               adv_n,
    input  logic               gwe_n,
    input  logic               bwe_n,
    input  logic [LANES-1:0]   lane_we_n,
    input  logic               flow_n,
    input  logic               seq_linear,
    input  logic               oe_n,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata,
    output logic               rvalid
);
    localparam int DW = LANES * 8;

    bsr_pkg::st_t     st, st_nxt;
    logic             ce_ok, start, desel, wr_req;
    logic             load, step, rd_live;
    logic [LANES-1:0] lane_mask;
    logic [AW-1:0]    cur_addr;
    logic [1:0]       base_lo;
    logic [DW-1:0]    core_rd;

    assign ce_ok  = cs_hi & ~cs_lo_a_n & ~cs_lo_b_n;
    assign start  = ~strobe_n & ce_ok;
    assign desel  = ~strobe_n & ~ce_ok;
    assign wr_req = ~gwe_n | ~bwe_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= bsr_pkg::S_IDLE;
        else        st <= st_nxt;
    end

    // Transitions: open, close, restart, beat
    always_comb begin
        st_nxt = st;
        unique case (st)
            bsr_pkg::S_IDLE:  if (start) st_nxt = bsr_pkg::S_BURST;
            bsr_pkg::S_BURST: if (desel) st_nxt = bsr_pkg::S_IDLE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        load      = start;
        step      = 1'b0;
        rd_live   = 1'b0;
        lane_mask = '0;
        unique case (st)
            bsr_pkg::S_IDLE: ;
            bsr_pkg::S_BURST: begin
                step    = strobe_n & ~adv_n;
                rd_live = ~wr_req;
                if (!gwe_n)      lane_mask = '1;
                else if (!bwe_n) lane_mask = ~lane_we_n;
            end
        endcase
    end

    bsr_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .linear   (seq_linear),
        .addr_in  (addr),
        .cur_addr (cur_addr),
        .base_lo  (base_lo)
    );

    bsr_lane_array #(.AW(AW), .LANES(LANES)) u_arr (
        .clk   (clk),
        .we    (lane_mask),
        .addr  (cur_addr),
        .wdata (wdata),
        .rdata (core_rd)
    );

    bsr_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_n    (flow_n),
        .oe_n      (oe_n),
        .live      (rd_live),
        .core_data (core_rd),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/bsr_chk.sv
`timescale 1ns/1ps
module bsr_chk #(
    parameter int AW = 6,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_hi,
    input logic          cs_lo_a_n,
    input logic          cs_lo_b_n,
    input logic          strobe_n,
    input logic          adv_n,
    input logic          flow_n,
    input logic          seq_linear,
    input logic          oe_n,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input bsr_pkg::st_t  st,
    input logic [AW-1:0] cur_addr,
    input logic [1:0]    base_lo
);
    logic ce_ok;
    assign ce_ok = cs_hi & ~cs_lo_a_n & ~cs_lo_b_n;

    always @(posedge clk) begin
        if (!rst_n) a_r1_reset_quiet: assert (!rvalid && rdata == '0);
    end

    a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && rdata == '0));

    a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_n && !strobe_n && !ce_ok) |=> !rvalid);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == bsr_pkg::S_BURST && strobe_n && adv_n) |=> $stable(cur_addr));

    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == bsr_pkg::S_BURST && strobe_n && !adv_n && seq_linear)
        |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

    a_r3_inter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == bsr_pkg::S_BURST && strobe_n && !adv_n && !seq_linear)
        |=> (cur_addr[1:0] ^ base_lo) == ($past(cur_addr[1:0] ^ base_lo) + 2'd1));

    a_r9_pipe_source: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_n && rvalid) |-> $past(st == bsr_pkg::S_BURST));
endmodule

bind burst_sram bsr_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_hi      (cs_hi),
    .cs_lo_a_n  (cs_lo_a_n),
    .cs_lo_b_n  (cs_lo_b_n),
    .strobe_n   (strobe_n),
    .adv_n      (adv_n),
    .flow_n     (flow_n),
    .seq_linear (seq_linear),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .st         (st),
    .cur_addr   (cur_addr),
    .base_lo    (base_lo)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_hi = 1'b0, cs_lo_a_n = 1'b1, cs_lo_b_n = 1'b1;
    logic          strobe_n = 1'b1, adv_n = 1'b1;
    logic          gwe_n = 1'b1, bwe_n = 1'b1;
    logic [7:0]    lane_we_n = 8'hFF;
    logic          flow_n = 1'b0, seq_linear = 1'b0, oe_n = 1'b0;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          rvalid;

    int            tests = 0;
    int            fails = 0;
    int            run = 0;
    int            run_max = 0;
    string         cur_tag = "R11";
    logic [63:0]   model [64];
    logic [63:0]   exp_q [$];

    always #4 clk = ~clk;

    burst_sram #(.AW(AW), .LANES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_hi(cs_hi),
        .cs_lo_a_n(cs_lo_a_n), .cs_lo_b_n(cs_lo_b_n), .strobe_n(strobe_n),
        .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
        .flow_n(flow_n), .seq_linear(seq_linear), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k);
        logic [1:0] kk = k[1:0];
        return {b[AW-1:2], seq_linear ? b[1:0] + kk : b[1:0] ^ kk};
    endfunction

    // Monitor: pops the scoreboard on every valid beat
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (rvalid) begin
                run++;
                if (run > run_max) run_max = run;
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected beat"}, rdata, '0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(rdata === e, cur_tag, rdata, e);
                end
            end else begin
                run = 0;
            end
        end
    end

    task automatic go_idle();
        strobe_n = 1'b1; adv_n = 1'b1; gwe_n = 1'b1; bwe_n = 1'b1;
        lane_we_n = 8'hFF; cs_hi = 1'b1; cs_lo_a_n = 1'b0; cs_lo_b_n = 1'b0;
    endtask

    task automatic deselect();
        strobe_n = 1'b0; cs_hi = 1'b0; adv_n = 1'b1;
    endtask

    task automatic start(input logic [AW-1:0] b, input bit gw, input bit bw, input logic [7:0] lanes);
        @(negedge clk);
        addr = b; strobe_n = 1'b0; adv_n = 1'b1;
        cs_hi = 1'b1; cs_lo_a_n = 1'b0; cs_lo_b_n = 1'b0;
        gwe_n = !gw; bwe_n = !bw; lane_we_n = lanes;
    endtask

    task automatic write_burst(input logic [AW-1:0] b, input bit gw, input bit bw,
                               input logic [7:0] lanes, input logic [63:0] seed);
        if (!gw && !bw) for (int k = 0; k < 4; k++) exp_q.push_back(model[beat_addr(b, k)]);
        start(b, gw, bw, lanes);
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a;
            @(negedge clk);
            a = beat_addr(b, k);
            wdata = seed + 64'h0101_0101_0101_0101 * k;
            if (k == 3) deselect();
            else begin strobe_n = 1'b1; adv_n = 1'b0; end
            for (int i = 0; i < 8; i++)
                if (gw || (bw && !lanes[i])) model[a][8*i +: 8] = wdata[8*i +: 8];
        end
        @(negedge clk);
        go_idle();
    endtask

    task automatic read_burst(input logic [AW-1:0] b, input bit hold, input bit last, input bit chk_lat);
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back(model[beat_addr(b, k)]);
            if (hold && k == 0) exp_q.push_back(model[beat_addr(b, 0)]);
        end
        start(b, 1'b0, 1'b0, 8'hFF);
        if (chk_lat) begin
            @(posedge clk); #2;
            chk(rvalid == flow_n ? 1'b0 : 1'b1, "R9 first-beat latency", {63'd0, rvalid}, {63'd0, ~flow_n});
        end
        if (hold) begin
            @(negedge clk); strobe_n = 1'b1; adv_n = 1'b1;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); strobe_n = 1'b1; adv_n = 1'b0;
        end
        if (last) begin
            @(negedge clk); deselect();
            @(negedge clk); go_idle();
        end
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic read_suite();
        // R3: interleaved order from unaligned starts
        seq_linear = 1'b0; cur_tag = "R3";
        read_burst(6'd6, 1'b0, 1'b1, 1'b1);
        read_burst(6'd33, 1'b0, 1'b1, 1'b0);
        drain();
        // R4: linear order
        seq_linear = 1'b1; cur_tag = "R4";
        read_burst(6'd13, 1'b0, 1'b1, 1'b1);
        read_burst(6'd63, 1'b0, 1'b1, 1'b0);
        drain();
        // R5: advance held for one edge repeats beat 0
        cur_tag = "R5";
        read_burst(6'd18, 1'b1, 1'b1, 1'b0);
        drain();
        // R12: chained bursts give eight consecutive beats
        cur_tag = "R12";
        run_max = 0;
        read_burst(6'd21, 1'b0, 1'b0, 1'b0);
        read_burst(6'd42, 1'b0, 1'b1, 1'b0);
        drain();
        chk(run_max == 8, "R12 consecutive valid cycles", 64'(run_max), 64'd8);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(rvalid == 1'b0 && rdata == '0, "R1 in reset", rdata, '0);
        @(negedge clk); rst_n = 1'b1; go_idle();
        @(posedge clk); #2;
        chk(rvalid == 1'b0 && rdata == '0, "R1 after reset", rdata, '0);

        // Fill every word with global-write bursts (R6, R11)
        flow_n = 1'b0; seq_linear = 1'b0; cur_tag = "R11";
        for (int b = 0; b < 64; b += 4)
            write_burst(b[AW-1:0], 1'b1, 1'b0, 8'hFF, 64'hC3A5_0000_0000_0000 + 64'(b) * 64'h0001_0003_0007_000B);
        drain();

        read_suite();

        // R7: sparse byte write, then read back
        seq_linear = 1'b1;
        write_burst(6'd22, 1'b0, 1'b1, 8'b0101_1010, 64'hDEAD_BEEF_0BAD_F00D);
        cur_tag = "R7";
        read_burst(6'd22, 1'b0, 1'b1, 1'b0);
        drain();
        // R6: global write overrides disabled lanes
        write_burst(6'd25, 1'b1, 1'b0, 8'hFF, 64'h1234_5678_9ABC_DEF0);
        cur_tag = "R6";
        read_burst(6'd25, 1'b0, 1'b1, 1'b0);
        drain();
        // R8: neither write control: beats read out, memory unchanged
        cur_tag = "R8";
        write_burst(6'd40, 1'b0, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        drain();
        read_burst(6'd40, 1'b0, 1'b1, 1'b0);
        drain();

        // R2: unqualified strobe gives no beats
        cur_tag = "R2";
        @(negedge clk); addr = 6'd5; strobe_n = 1'b0; cs_lo_a_n = 1'b1;
        @(posedge clk); #2;
        chk(rvalid == 1'b0, "R2 deselected strobe", {63'd0, rvalid}, 64'd0);
        @(negedge clk); go_idle(); cs_lo_b_n = 1'b1;
        @(posedge clk); #2;
        chk(rvalid == 1'b0, "R2 idle after deselect", {63'd0, rvalid}, 64'd0);
        @(negedge clk); go_idle();
        drain();

        // R10: asynchronous output enable
        cur_tag = "R10";
        @(negedge clk); oe_n = 1'b1;
        start(6'd9, 1'b0, 1'b0, 8'hFF);
        @(posedge clk); #1;
        chk(rvalid == 1'b0 && rdata == '0, "R10 oe high", rdata, '0);
        #2; oe_n = 1'b0;
        #1;
        chk(rvalid == 1'b1 && rdata == model[9], "R10 oe restored", rdata, model[9]);
        oe_n = 1'b1; deselect();
        @(negedge clk); go_idle(); oe_n = 1'b0;
        drain();

        // Registered read mode: same read set (R9)
        flow_n = 1'b1;
        read_suite();
        seq_linear = 1'b0;
        write_burst(6'd50, 1'b0, 1'b1, 8'b1111_0000, 64'h0F1E_2D3C_4B5A_6978);
        cur_tag = "R9";
        read_burst(6'd50, 1'b0, 1'b1, 1'b1);
        drain();

        chk(exp_q.size() == 0, "R11 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule